// File: doc/BRIEF.md
# Multi-Method Defuzzification Unit

This block turns the fuzzy result of an inference step into one crisp output coordinate. The fuzzy result is a membership curve sampled at `PTS` output positions, each sample `MW` bits wide (256 positions of 8 bits by default). An upstream sequencer writes the samples one per strobe into one of two storage banks. A run request starts the unit on the other bank, so the next curve can be written while the current one is reduced.

While a run is in progress, the unit streams the stored curve out unchanged on a separate fuzzy port. A system that needs only the fuzzy result reads that port and picks the pass-through mode. The crisp methods are:

- centroid: the weighted mean position;
- bisector of area: the first position where the accumulated membership reaches half of the total;
- first, last and middle of the maximum plateau.

Centroid needs a division, which a restoring divider inside the block performs one bit per cycle. A ready flag shows when the crisp output is valid.

Top module: `dfz_unit`

## Requirements
- R1: Each cycle with `fill_stb` high writes `fill_mu` into the bank named by `bank_sel` (0 or 1). The write position is 0 after reset and 0 in the first cycle after `bank_sel` changes, and each strobe moves it up by one.
- R2: With `ready` high, a cycle with `run` high captures `mode` and selects the bank opposite to the current `bank_sel`. `ready` is low in the following cycle. Later changes of `bank_sel` and later fills do not alter the curve being processed.
- R3: During each run, `fz_valid` is high for exactly `PTS` consecutive cycles. In those cycles `fz_idx` steps from 0 to `PTS-1` and `fz_mu` carries the stored sample at that position.
- R4: Mode 0 (centroid) gives floor(sum of y·μ(y) / sum of μ(y)), or 0 when every sample is zero.
- R5: Mode 1 (bisector) gives the smallest y at which twice the running sum of μ up to and including y is at least the total sum. When every sample is zero, this gives 0.
- R6: Mode 2 gives the lowest y whose μ equals the maximum. Mode 3 gives the highest such y. For an all-zero curve these are 0 and `PTS-1`.
- R7: Mode 4 gives floor((first-of-maximum + last-of-maximum) / 2).
- R8: Modes 5, 6 and 7 are pass-through: the fuzzy stream is produced as in R3 and `crisp_y` becomes 0.
- R9: `ready` rises in the same cycle that `crisp_y` takes the new result. `crisp_y` then holds its value for as long as `ready` stays high.
- R10: A `run` pulse while `ready` is low is ignored. The current run finishes with its own mode and curve.
- R11: After reset `ready` is 1, `crisp_y` is 0 and `fz_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fill_stb | input | 1 | Writes one membership sample into the fill bank |
| bank_sel | input | 1 | Bank being filled; runs use the other bank |
| fill_mu | input | MW | Membership sample to write |
| run | input | 1 | Starts a reduction when ready |
| mode | input | 3 | 0 centroid, 1 bisector, 2 first max, 3 last max, 4 middle max, 5-7 fuzzy only |
| ready | output | 1 | High when idle with a valid crisp result |
| crisp_y | output | log2(PTS) | Crisp output position |
| fz_valid | output | 1 | Fuzzy stream sample valid |
| fz_idx | output | log2(PTS) | Position of the streamed sample |
| fz_mu | output | MW | Streamed membership sample |

## Verification
The hardest situation to create from the ports is a fill of one bank at the same time as a run on the other bank. To reach it, the bench forks a full-length fill of the next curve alongside the first run on each curve. Every later mode then re-reads the untouched bank, which would show any corruption.

Ties are also hard to reach with random data. Directed curves cover them: a flat maximum, two separated equal plateaus, single spikes at both ends, and an all-zero curve. Together these cover equal maxima, zero totals and half-area crossings at the ends.

// File: rtl/dfz_pkg.sv
package dfz_pkg;
   typedef enum logic [2:0] {
      MD_CENTROID = 3'd0,
      MD_BISECT   = 3'd1,
      MD_FIRSTMAX = 3'd2,
      MD_LASTMAX  = 3'd3,
      MD_MIDMAX   = 3'd4,
      MD_FUZZY    = 3'd5
   } dfz_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN,
      ST_AREA,
      ST_DIVGO,
      ST_DIV,
      ST_DONE
   } dfz_state_e;
endpackage

// File: rtl/dfz_bank.sv
module dfz_bank #(
   parameter int PTS = 256,
   parameter int MW  = 8,
   localparam int YW = $clog2(PTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fill_stb,
   input  logic          fill_bank,
   input  logic [MW-1:0] fill_mu,
   input  logic          rd_bank,
   input  logic [YW-1:0] rd_addr,
   output logic [MW-1:0] rd_mu
);
   logic [YW-1:0] wr_ptr;
   logic          last_bank;
   logic [YW-1:0] wr_eff;
   logic [MW-1:0] bank_rd [2];

   // a change of fill bank restarts the write position at zero
   assign wr_eff = (fill_bank != last_bank) ? '0 : wr_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         last_bank <= 1'b0;
      end else begin
         last_bank <= fill_bank;
         wr_ptr    <= fill_stb ? wr_eff + 1'b1 : wr_eff;
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [MW-1:0] cells [PTS];
      always_ff @(posedge clk) begin
         if (fill_stb && (fill_bank == 1'(b)))
            cells[wr_eff] <= fill_mu;
      end
      assign bank_rd[b] = cells[rd_addr];
   end

   assign rd_mu = bank_rd[rd_bank];
endmodule

// File: rtl/dfz_div.sv
module dfz_div #(
   parameter int NW = 24,
   parameter int DW = 16,
   parameter int QW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          done,
   output logic [QW-1:0] quo
);
   localparam int CW = $clog2(NW + 1);

   if (QW >= NW) begin : g_chk
      $error("dfz_div: quotient width must be below numerator width");
   end

   logic [DW-1:0] rem;
   logic [NW-1:0] nsh;
   logic [CW-1:0] cnt;
   logic [DW:0]   trial;

   assign trial = {rem, nsh[NW-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem  <= '0;
         nsh  <= '0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem <= '0;
            nsh <= num;
            cnt <= CW'(NW);
         end else if (cnt != '0) begin
            if (trial >= {1'b0, den}) begin
               rem <= DW'(trial - {1'b0, den});
               nsh <= {nsh[NW-2:0], 1'b1};
            end else begin
               rem <= trial[DW-1:0];
               nsh <= {nsh[NW-2:0], 1'b0};
            end
            cnt  <= cnt - 1'b1;
            done <= (cnt == CW'(1));
         end
      end
   end

   // clamp: an out-of-range quotient saturates instead of wrapping
   assign quo = (|nsh[NW-1:QW]) ? '1 : nsh[QW-1:0];
endmodule

// File: rtl/dfz_unit.sv
module dfz_unit
   import dfz_pkg::*;
#(
   parameter int PTS = 256,
   parameter int MW  = 8,
   localparam int YW = $clog2(PTS),
   localparam int SW = MW + YW,
   localparam int WW = SW + YW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fill_stb,
   input  logic          bank_sel,
   input  logic [MW-1:0] fill_mu,
   input  logic          run,
   input  logic [2:0]    mode,
   output logic          ready,
   output logic [YW-1:0] crisp_y,
   output logic          fz_valid,
   output logic [YW-1:0] fz_idx,
   output logic [MW-1:0] fz_mu
);
   if (PTS != (1 << YW) || PTS < 4) begin : g_pts_chk
      $error("dfz_unit: PTS must be a power of two, at least 4");
   end
   if (MW < 1) begin : g_mw_chk
      $error("dfz_unit: MW must be positive");
   end

   dfz_state_e    state;
   logic [2:0]    mode_q;
   logic          proc_bank;
   logic [YW-1:0] idx;
   logic [MW-1:0] mu;
   logic [SW-1:0] sum_s, run_sum, run_nxt;
   logic [WW-1:0] sum_w;
   logic [MW-1:0] mx;
   logic [YW-1:0] fpos, lpos, coa_y, div_q, result;
   logic [YW:0]   mid_sum;
   logic          div_done;
   logic          last_pt;

   dfz_bank #(.PTS(PTS), .MW(MW)) u_bank (
      .clk(clk), .rst_n(rst_n), .fill_stb(fill_stb), .fill_bank(bank_sel),
      .fill_mu(fill_mu), .rd_bank(proc_bank), .rd_addr(idx), .rd_mu(mu)
   );

   dfz_div #(.NW(WW), .DW(SW), .QW(YW)) u_div (
      .clk(clk), .rst_n(rst_n), .start(state == ST_DIVGO),
      .num(sum_w), .den(sum_s), .done(div_done), .quo(div_q)
   );

   assign last_pt = (idx == YW'(PTS - 1));
   assign run_nxt = run_sum + SW'(mu);
   assign mid_sum = {1'b0, fpos} + {1'b0, lpos};

   always_comb begin
      case (dfz_mode_e'(mode_q))
         MD_CENTROID: result = (sum_s == '0) ? '0 : div_q;
         MD_BISECT:   result = coa_y;
         MD_FIRSTMAX: result = fpos;
         MD_LASTMAX:  result = lpos;
         MD_MIDMAX:   result = mid_sum[YW:1];
         default:     result = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mode_q    <= '0;
         proc_bank <= 1'b0;
         idx       <= '0;
         sum_s     <= '0;
         sum_w     <= '0;
         run_sum   <= '0;
         mx        <= '0;
         fpos      <= '0;
         lpos      <= '0;
         coa_y     <= '0;
         ready     <= 1'b1;
         crisp_y   <= '0;
         fz_valid  <= 1'b0;
         fz_idx    <= '0;
         fz_mu     <= '0;
      end else begin
         fz_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (run) begin
                  mode_q    <= mode;
                  proc_bank <= ~bank_sel;
                  ready     <= 1'b0;
                  idx       <= '0;
                  sum_s     <= '0;
                  sum_w     <= '0;
                  state     <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               fz_valid <= 1'b1;
               fz_idx   <= idx;
               fz_mu    <= mu;
               sum_s    <= sum_s + SW'(mu);
               sum_w    <= sum_w + WW'(idx) * WW'(mu);
               if (idx == '0 || mu > mx) begin
                  mx   <= mu;
                  fpos <= idx;
                  lpos <= idx;
               end else if (mu == mx) begin
                  lpos <= idx;
               end
               idx <= idx + 1'b1;
               if (last_pt) begin
                  run_sum <= '0;
                  case (dfz_mode_e'(mode_q))
                     MD_CENTROID: state <= ST_DIVGO;
                     MD_BISECT:   state <= ST_AREA;
                     default:     state <= ST_DONE;
                  endcase
               end
            end
            ST_AREA: begin
               run_sum <= run_nxt;
               if (({run_nxt, 1'b0} >= {1'b0, sum_s}) || last_pt) begin
                  coa_y <= idx;
                  state <= ST_DONE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_DIVGO: state <= ST_DIV;
            ST_DIV:   if (div_done) state <= ST_DONE;
            default: begin
               crisp_y <= result;
               ready   <= 1'b1;
               state   <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/dfz_unit_chk.sv
module dfz_unit_chk #(
   parameter int PTS = 256,
   localparam int YW = $clog2(PTS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          ready,
   input logic [YW-1:0] crisp_y,
   input logic          fz_valid,
   input logic [YW-1:0] fz_idx
);
   // R2: an accepted run request lowers ready in the next cycle
   a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      ready && run |=> !ready);

   // R3: the fuzzy stream walks the positions in order
   a_r3_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
      fz_valid && $past(fz_valid) |-> fz_idx == YW'($past(fz_idx) + 1'b1));

   // R3: every stream starts at position zero
   a_r3_stream_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fz_valid) |-> fz_idx == '0);

   // R3: streaming only happens while a run is busy
   a_r3_stream_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      fz_valid |-> !ready);

   // R9: the crisp result holds while ready stays high
   a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      ready && $past(ready) |-> $stable(crisp_y));
endmodule

bind dfz_unit dfz_unit_chk #(.PTS(PTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .ready(ready),
   .crisp_y(crisp_y), .fz_valid(fz_valid), .fz_idx(fz_idx)
);

// File: tb/tb_dfz_unit.sv
module tb_dfz_unit;
   localparam int PTS  = 256;
   localparam int MW   = 8;
   localparam int YW   = 8;
   localparam int NPAT = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fill_stb = 1'b0;
   logic          bank_sel = 1'b0;
   logic [MW-1:0] fill_mu = '0;
   logic          run = 1'b0;
   logic [2:0]    mode = '0;
   logic          ready;
   logic [YW-1:0] crisp_y;
   logic          fz_valid;
   logic [YW-1:0] fz_idx;
   logic [MW-1:0] fz_mu;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit finished = 0;

   logic [MW-1:0] pat [NPAT][PTS];
   logic [MW-1:0] cap [PTS];
   int            cap_cnt = 0;

   dfz_unit #(.PTS(PTS), .MW(MW)) dut (.*);

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (fz_valid) begin
         cap[fz_idx] = fz_mu;
         cap_cnt = cap_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   function automatic int ref_crisp(input int m, input int p);
      longint s = 0, w = 0, r = 0;
      int mxv = 0, fp = 0, lp = 0;
      for (int y = 0; y < PTS; y++) begin
         s += pat[p][y];
         w += longint'(y) * pat[p][y];
         if (y == 0 || int'(pat[p][y]) > mxv) begin
            mxv = pat[p][y]; fp = y; lp = y;
         end else if (int'(pat[p][y]) == mxv) lp = y;
      end
      case (m)
         0: return (s == 0) ? 0 : int'((w / s) % PTS);
         1: begin
            for (int y = 0; y < PTS; y++) begin
               r += pat[p][y];
               if (2 * r >= s) return y;
            end
            return PTS - 1;
         end
         2: return fp;
         3: return lp;
         4: return (fp + lp) / 2;
         default: return 0;
      endcase
   endfunction

   task automatic fill(input int p);
      for (int i = 0; i < PTS; i++) begin
         @(negedge clk);
         fill_stb = 1'b1;
         fill_mu  = pat[p][i];
      end
      @(negedge clk);
      fill_stb = 1'b0;
   endtask

   // run one reduction; busy_mode >= 0 injects a second run request mid-run (R10)
   task automatic do_run(input int m, input int p, input int busy_mode);
      int n = 0;
      int bad = 0;
      @(negedge clk);
      run = 1'b1;
      mode = 3'(m);
      cap_cnt = 0;
      @(negedge clk);
      run = 1'b0;
      check(ready == 1'b0, "R2 ready low after run", int'(ready), 0);
      if (busy_mode >= 0) begin
         repeat (7) @(negedge clk);
         run = 1'b1;
         mode = 3'(busy_mode);
         @(negedge clk);
         run = 1'b0;
      end
      while (!ready && n < 5000) begin
         @(negedge clk);
         n++;
      end
      check(ready == 1'b1, "R9 ready returns", int'(ready), 1);
      case (m)
         0: check(int'(crisp_y) == ref_crisp(m, p), "R4 centroid", int'(crisp_y), ref_crisp(m, p));
         1: check(int'(crisp_y) == ref_crisp(m, p), "R5 bisector", int'(crisp_y), ref_crisp(m, p));
         2, 3: check(int'(crisp_y) == ref_crisp(m, p), "R6 first/last max", int'(crisp_y), ref_crisp(m, p));
         4: check(int'(crisp_y) == ref_crisp(m, p), "R7 middle max", int'(crisp_y), ref_crisp(m, p));
         default: check(int'(crisp_y) == 0, "R8 fuzzy-only crisp", int'(crisp_y), 0);
      endcase
      check(cap_cnt == PTS, "R3 stream length", cap_cnt, PTS);
      for (int i = 0; i < PTS; i++) if (cap[i] !== pat[p][i]) bad++;
      check(bad == 0, "R1/R3 streamed samples", bad, 0);
   endtask

   initial begin
      int cur = 0;
      int held;
      void'($urandom(32'd2024));
      for (int y = 0; y < PTS; y++) begin
         pat[0][y] = '0;
         pat[1][y] = (y == 0) ? 8'd200 : 8'd0;
         pat[2][y] = (y == PTS - 1) ? 8'd1 : 8'd0;
         pat[3][y] = 8'd255;
         pat[4][y] = ((y >= 40 && y <= 60) || (y >= 150 && y <= 170)) ? 8'd180 : 8'(y % 37);
      end
      for (int p = 5; p < NPAT; p++)
         for (int y = 0; y < PTS; y++)
            pat[p][y] = (p % 2 == 1) ? 8'($urandom_range(0, 255))
                                     : (($urandom_range(0, 7) == 0) ? 8'($urandom_range(1, 255)) : 8'd0);

      repeat (3) @(negedge clk);
      check(ready == 1'b1, "R11 reset ready", int'(ready), 1);
      check(crisp_y == '0, "R11 reset crisp", int'(crisp_y), 0);
      check(fz_valid == 1'b0, "R11 reset stream idle", int'(fz_valid), 0);
      rst_n = 1'b1;

      fill(0);
      for (int p = 0; p < NPAT; p++) begin
         @(negedge clk);
         bank_sel = ~bank_sel;
         fork
            begin
               for (int m = 0; m < 6; m++) do_run(m, p, -1);
               if (p == 4) begin
                  do_run(2, p, 3);   // R10: mid-run request for last-max ignored
                  do_run(7, p, -1);  // R8: code 7 also fuzzy-only
               end
            end
            begin
               if (p + 1 < NPAT) fill(p + 1);
            end
         join
         cur = 1 - cur;
      end

      held = int'(crisp_y);
      repeat (20) @(negedge clk);
      check(ready == 1'b1 && int'(crisp_y) == held, "R9 result held while ready",
            int'(crisp_y), held);
      summary();
   end

   initial begin
      wait (cyc >= 190000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
   end
endmodule